// File: doc/BRIEF.md
# Vectored Interrupt Priority and In-Service Unit

This unit collects interrupt requests, each tagged with an 8-bit vector, and decides which one the processor should take next. Each vector has a pending bit and an in-service bit. The upper four bits of a vector form its priority class, where 15 is the most urgent. A programmable task-priority threshold and the class already being serviced both gate what is offered.

The processor sees one offered vector at a time and takes it with an acknowledge. The acknowledged vector moves from pending to in-service. Before returning, the handler writes the end-of-interrupt register, which retires the most urgent in-service vector.

Because a handler can be interrupted by a higher class, the in-service state can hold several classes at once. Retirement therefore always falls on the highest one, and the handler that was interrupted becomes current again.

Requests enter on a valid/ready stream. `req_ready` is high in every cycle out of reset, so a request is taken in any cycle where `req_valid` is high; no request is ever stalled.

The offered interrupt is a second valid/ready pair: `intr_valid` with `intr_ack` acting as ready. The unit keeps offering the same vector until it is taken, unless a more urgent one arrives. `intr_ack` has no effect while `intr_valid` is low.

Software reaches the threshold, the retirement command and the bit arrays through a plain synchronous register port with 32-bit data.

Top module: `vec_prio_unit`

## Requirements
- R1: The class of a vector is its bits [7:4]. The offered vector `intr_vector` is always the highest-numbered pending vector.
- R2: A request whose vector is below 32 is dropped. It sets no pending bit and is never offered.
- R3: The task-priority register sits at address 0x080 and reads back what was written. When its bits [7:4] equal 15, `intr_valid` stays low whatever is pending.
- R4: A pending vector is offered only when its class is strictly greater than the task-priority class (bits [7:4] of 0x080) and, if any vector is in service, strictly greater than the class of the highest in-service vector. An equal class waits.
- R5: A clock edge with `intr_valid` and `intr_ack` both high clears that vector's pending bit and sets its in-service bit at that same edge.
- R6: A write to address 0x0B0, with any data, clears only the highest set in-service bit. A lower-class handler that was interrupted then becomes current again. With nothing in service, the write has no effect.
- R7: In-service word n reads at address 0x100 + 0x10*n, and pending word n reads at 0x200 + 0x10*n, for n = 0..7. Bit b of word n stands for vector 32n+b. Read data is on `reg_rdata` in the cycle after `reg_rd`. Unmapped addresses read 0.
- R8: `svc_valid` is high exactly when some in-service bit is set, and `svc_vector` then gives the highest set in-service vector.
- R9: `req_ready` is high out of reset. A request for a vector that is already pending merges with it, so one acknowledge and one retirement consume both.
- R10: After reset, all pending and in-service bits and the task-priority register are 0. Both `intr_valid` and `svc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (high out of reset) |
| req_vector | input | 8 | Requested vector |
| intr_valid | output | 1 | A vector is offered to the processor |
| intr_vector | output | 8 | Offered vector |
| intr_ack | input | 1 | Processor takes the offered vector |
| svc_valid | output | 1 | Some vector is in service |
| svc_vector | output | 8 | Highest in-service vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after `reg_rd` |

## Verification
A corrupted pending or in-service bit appears at the ports in the very next cycle. It shows up as a wrong or missing `intr_vector`, or as a `svc_vector` that does not match the handler nesting the bench expects, because both are combinational views of the bit arrays. A class comparison that is off by one shows as an offer that comes too early or never comes, at the equal-class and threshold boundaries. A retirement aimed at the wrong bit shows as `svc_vector` failing to fall back to the interrupted handler after one end-of-interrupt write. It also shows in the in-service words read one cycle later.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam logic [11:0] ADDR_TASKPRI = 12'h080;
  localparam logic [11:0] ADDR_RETIRE  = 12'h0B0;
  localparam logic [3:0]  PAGE_INSVC   = 4'h1;
  localparam logic [3:0]  PAGE_PEND    = 4'h2;

  typedef struct packed {
    logic       any;
    logic [7:0] idx;
  } top_bit_t;
endpackage

// File: rtl/vp_msb_find.sv
module vp_msb_find #(
  parameter int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vp_bit_store.sv
module vp_bit_store #(
  parameter int N  = 256,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  bits
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit_set, hit_clr;
    assign hit_set = set_en && (set_idx == IW'(g));
    assign hit_clr = clr_en && (clr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)       bits[g] <= 1'b0;
      else if (hit_set) bits[g] <= 1'b1;
      else if (hit_clr) bits[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_prio_unit.sv
module vec_prio_unit
  import vp_pkg::*;
#(
  parameter int NVEC  = 256,
  parameter int NRESV = 32,
  parameter int DW    = 32,
  localparam int VW    = $clog2(NVEC),
  localparam int CW    = VW - 4,
  localparam int NWORD = NVEC / DW,
  localparam int WIW   = $clog2(NWORD),
  localparam int BW    = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [VW-1:0] req_vector,
  output logic          intr_valid,
  output logic [VW-1:0] intr_vector,
  input  logic          intr_ack,
  output logic          svc_valid,
  output logic [VW-1:0] svc_vector,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [11:0]   reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  logic [NVEC-1:0] pend, insvc;
  logic            pend_any, insvc_any;
  logic [VW-1:0]   pend_top, insvc_top;
  logic [DW-1:0]   taskpri_q;
  logic            take, retire, req_take;
  logic [CW-1:0]   pend_cls, insvc_cls, thr_cls;

  assign req_ready = rst_n;
  assign req_take  = req_valid && req_ready && (req_vector >= VW'(NRESV));

  vp_msb_find #(.N(NVEC)) u_pend_top (.bits(pend),  .any(pend_any),  .idx(pend_top));
  vp_msb_find #(.N(NVEC)) u_svc_top  (.bits(insvc), .any(insvc_any), .idx(insvc_top));

  assign pend_cls  = pend_top[VW-1 -: CW];
  assign insvc_cls = insvc_top[VW-1 -: CW];
  assign thr_cls   = taskpri_q[7:4];

  assign intr_valid  = pend_any && (pend_cls > thr_cls) &&
                       (!insvc_any || (pend_cls > insvc_cls));
  assign intr_vector = pend_top;
  assign take        = intr_valid && intr_ack;
  assign retire      = reg_wr && (reg_addr == ADDR_RETIRE) && insvc_any;
  assign svc_valid   = insvc_any;
  assign svc_vector  = insvc_top;

  // New request wins over an acknowledge of the same vector in one cycle.
  vp_bit_store #(.N(NVEC)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_take), .set_idx(req_vector),
    .clr_en(take),     .clr_idx(pend_top),
    .bits(pend)
  );

  vp_bit_store #(.N(NVEC)) u_insvc (
    .clk(clk), .rst_n(rst_n),
    .set_en(take),   .set_idx(pend_top),
    .clr_en(retire), .clr_idx(insvc_top),
    .bits(insvc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      taskpri_q <= '0;
    else if (reg_wr && (reg_addr == ADDR_TASKPRI))
      taskpri_q <= reg_wdata;
  end

  logic [3:0]     widx;
  logic           word_ok;
  logic [DW-1:0]  rd_mux;
  logic [VW-1:0]  wbase;
  assign widx    = reg_addr[7:4];
  assign word_ok = (reg_addr[3:0] == 4'h0) && (int'(widx) < NWORD);
  assign wbase   = {widx[WIW-1:0], BW'(0)};

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_TASKPRI)
      rd_mux = taskpri_q;
    else if (word_ok && reg_addr[11:8] == PAGE_INSVC)
      rd_mux = insvc[wbase +: DW];
    else if (word_ok && reg_addr[11:8] == PAGE_PEND)
      rd_mux = pend[wbase +: DW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    intr_valid |-> (intr_vector >= VW'(NRESV)));
  p_full_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (taskpri_q[7:4] == 4'hF) |-> !intr_valid);
  p_nest_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (intr_valid && svc_valid) |-> (intr_vector[VW-1 -: CW] > svc_vector[VW-1 -: CW]));
  p_ack_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> insvc[$past(intr_vector)]);
  p_retire_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !take) |=> ($countones(insvc) == $countones($past(insvc)) - 1));
  p_svc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid == (insvc != '0));
endmodule

// File: tb/tb_vec_prio_unit.sv
module tb_vec_prio_unit;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [7:0]  req_vector = 0;
  logic        intr_valid, intr_ack = 0;
  logic [7:0]  intr_vector;
  logic        svc_valid;
  logic [7:0]  svc_vector;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  exp_q[$];
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  vec_prio_unit dut (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each acknowledge must take the queued expected vector.
  always @(negedge clk) begin
    if (rst_n && intr_ack) begin
      if (exp_q.size() == 0) chk(32'(intr_vector), 32'hFFFF, "R5 unexpected ack");
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk({23'd0, intr_valid, intr_vector}, {24'd1, e}, "R1/R5 acknowledged vector");
      end
    end
  end

  task automatic send(input logic [7:0] v);
    req_valid = 1; req_vector = v;
    @(posedge clk); #1 req_valid = 0;
  endtask
  task automatic ack(input logic [7:0] v);
    exp_q.push_back(v); intr_ack = 1;
    @(posedge clk); #1 intr_ack = 0;
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1 reg_rd = 0; d = reg_rdata;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    chk(intr_valid, 0, "R10 intr_valid after reset");
    chk(svc_valid, 0, "R10 svc_valid after reset");
    chk(req_ready, 1, "R9 req_ready");
    rd(12'h080, rv); chk(rv, 0, "R10 task priority reset");
    // R2 reserved vector dropped
    send(8'h10);
    chk(intr_valid, 0, "R2 reserved not offered");
    rd(12'h200, rv); chk(rv, 0, "R2 pending word0");
    // R1 highest offered
    send(8'h45); send(8'h62); send(8'h63);
    chk(intr_vector, 8'h63, "R1 highest pending");
    ack(8'h63);
    chk({svc_valid, svc_vector}, 9'h163, "R8 svc after ack");
    rd(12'h230, rv); chk(rv, 32'h4, "R5 R7 pending word3");
    rd(12'h130, rv); chk(rv, 32'h8, "R5 R7 in-service word3");
    chk(intr_valid, 0, "R4 equal class waits");
    // nesting
    send(8'h91);
    chk({intr_valid, intr_vector}, 9'h191, "R4 higher class offered");
    ack(8'h91);
    rd(12'h140, rv); chk(rv, 32'h0002_0000, "R7 in-service word4");
    chk(svc_vector, 8'h91, "R8 nested svc");
    wr(12'h0B0, 32'h0);
    chk({svc_valid, svc_vector}, 9'h163, "R6 return to interrupted");
    rd(12'h140, rv); chk(rv, 0, "R6 word4 cleared");
    wr(12'h0B0, 32'h0);
    chk(svc_valid, 0, "R6 all retired");
    chk({intr_valid, intr_vector}, 9'h162, "R4 offered after retire");
    ack(8'h62); wr(12'h0B0, 32'h0);
    // threshold
    wr(12'h080, 32'h40);
    rd(12'h080, rv); chk(rv, 32'h40, "R3 task priority readback");
    chk(intr_valid, 0, "R4 class equal to threshold waits");
    wr(12'h080, 32'h30);
    chk({intr_valid, intr_vector}, 9'h145, "R4 class above threshold");
    wr(12'h080, 32'hF0);
    send(8'hF5);
    chk(intr_valid, 0, "R3 class 15 masks all");
    wr(12'h080, 32'h0);
    chk({intr_valid, intr_vector}, 9'h1F5, "R1 top class offered");
    ack(8'hF5);
    chk(intr_valid, 0, "R4 lower class blocked by class 15");
    wr(12'h0B0, 32'h0);
    ack(8'h45); wr(12'h0B0, 32'h0);
    wr(12'h0B0, 32'h0);
    chk(svc_valid, 0, "R6 retire with none in service");
    // R9 duplicate merge
    send(8'h80); send(8'h80);
    ack(8'h80); wr(12'h0B0, 32'h0);
    chk({intr_valid, svc_valid}, 0, "R9 duplicate merged");
    rd(12'h300, rv); chk(rv, 0, "R7 unmapped read");
    chk(exp_q.size(), 0, "R5 scoreboard drained");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule